// File: doc/BRIEF.md
# Single-Bit Modify and Test Engine

This block applies one single-bit operation to a byte and returns the modified byte together with the next jump, zero and carry flags. Six operations are supported: force the addressed bit high, force it low, invert it, copy the carry flag into it, copy it into the carry flag (a bit test), and fold it into the carry flag by exclusive-or. The first four produce a byte to be written back; the last two only update flags.

A request arrives on a valid/ready port. In register form the operand byte travels with the request and the result appears two cycles after acceptance. In memory form the request carries a pointer instead. The engine then issues a read, waits for the read data, computes the result, and for the four writing operations issues a write of the new byte to the same pointer. When the operation is clear or invert, the read is marked as a latch read so that a port register returns its output latch rather than its pins. A one-cycle completion pulse marks the moment the result outputs are valid.

Top module: `bitop_unit`

## Requirements
- R1: For the set (code 0), clear (code 1) and invert (code 2) operations, the zero flag and the jump flag both equal the inverse of the addressed bit as it was before modification.
- R2: Set forces the addressed bit to 1, clear forces it to 0, invert flips it; every other bit of the byte is unchanged and res_we is 1. The carry flag passes through unchanged.
- R3: Store-carry (code 3) writes req_cf into the addressed bit, leaves the other bits and the zero and carry flags unchanged, sets res_we to 1 and always sets the jump flag to 1.
- R4: Load-carry (codes 4 and 6) sets the carry flag to the addressed bit and the jump flag to its inverse; res_we is 0, res_byte equals the operand byte and the zero flag passes through.
- R5: Exclusive-or carry (codes 5 and 7) sets the carry flag to req_cf XOR the addressed bit and the jump flag to that new carry; res_we is 0 and the zero flag passes through.
- R6: The bit index is the low three bits of req_bitsel; its upper bits have no effect on any output.
- R7: In memory form, mem_rd_latch is 1 throughout the read for the clear and invert operations and 0 for all others.
- R8: req_ready is 1 exactly when the engine is idle; a request is taken when req_valid and req_ready are both 1. mem_rd_req stays 1 with a stable mem_addr equal to the request pointer until a cycle with mem_rd_valid.
- R9: In memory form the write is issued only for codes 0 to 3; mem_wr_req then stays 1 with mem_wr_data equal to the modified byte until a cycle with mem_wr_ack. Codes 4 to 7 issue no write.
- R10: res_valid is a single-cycle pulse; in register form it rises two clock edges after acceptance, in memory form on the edge after the read completes (no write) or after the write is acknowledged.
- R11: After reset req_ready is 1 and mem_rd_req, mem_wr_req and res_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_mem | input | 1 | 1 = memory form using req_ptr, 0 = register form using req_operand |
| req_op | input | 3 | Operation code (see R1 to R5) |
| req_bitsel | input | SEL_W | Bit index source; low three bits used |
| req_operand | input | DATA_W | Operand byte for register form |
| req_ptr | input | ADDR_W | Byte pointer for memory form |
| req_cf | input | 1 | Current carry flag |
| req_zf | input | 1 | Current zero flag |
| res_valid | output | 1 | One-cycle completion pulse |
| res_byte | output | DATA_W | Resulting byte |
| res_we | output | 1 | Byte must be written back |
| res_jf | output | 1 | Next jump flag |
| res_zf | output | 1 | Next zero flag |
| res_cf | output | 1 | Next carry flag |
| mem_addr | output | ADDR_W | Read and write pointer |
| mem_rd_req | output | 1 | Read request, held until mem_rd_valid |
| mem_rd_latch | output | 1 | Read targets output latch rather than pins |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | DATA_W | Read data |
| mem_wr_req | output | 1 | Write request, held until mem_wr_ack |
| mem_wr_data | output | DATA_W | Write data |
| mem_wr_ack | input | 1 | Write accepted |

## Verification
Each operation is driven with the addressed bit both 0 and 1 so the flag rules that depend on the original bit are separated from ones that do not, and the carry operations are run with both carry values so copy, test and exclusive-or cannot be confused. Operands with many ones next to the target bit expose a mask that disturbs neighbours, and a bit selector with non-zero upper bits shows whether only the low three bits steer the index. Memory-form runs use read and write latencies of one to four cycles, which distinguishes a held request from a one-shot one, and compare writing against test-only operations to show the write is skipped.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [2:0] {
    BOP_SET = 3'd0,
    BOP_CLR = 3'd1,
    BOP_CPL = 3'd2,
    BOP_STC = 3'd3,
    BOP_LDC = 3'd4,
    BOP_XRC = 3'd5
  } bop_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_WRITE
  } bop_state_e;

  // Codes with bit 2 clear produce a byte to write back.
  function automatic logic op_writes(input logic [2:0] op);
    return !op[2];
  endfunction

  // Clear and invert must see the output latch of a port register.
  function automatic logic op_reads_latch(input logic [2:0] op);
    return (op == BOP_CLR) || (op == BOP_CPL);
  endfunction
endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] mask
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask[i] = (idx == IDX_W'(i));
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic [IDX_W-1:0]  idx,
  input  logic [2:0]        op,
  input  logic              cf_in,
  input  logic              zf_in,
  output logic [DATA_W-1:0] data_out,
  output logic              we,
  output logic              jf_out,
  output logic              zf_out,
  output logic              cf_out
);
  logic [DATA_W-1:0] mask;
  logic              orig;

  bitop_mask #(.DATA_W(DATA_W)) u_mask (.idx(idx), .mask(mask));

  assign orig = |(data_in & mask);

  always_comb begin
    data_out = data_in;
    we       = op_writes(op);
    jf_out   = 1'b1;
    zf_out   = zf_in;
    cf_out   = cf_in;
    if (!op[2]) begin
      unique case (op[1:0])
        2'd0: data_out = data_in | mask;
        2'd1: data_out = data_in & ~mask;
        2'd2: data_out = data_in ^ mask;
        default: data_out = cf_in ? (data_in | mask) : (data_in & ~mask);
      endcase
      if (op[1:0] != 2'd3) begin
        zf_out = !orig;
        jf_out = !orig;
      end
    end else if (op[0]) begin
      cf_out = cf_in ^ orig;
      jf_out = cf_in ^ orig;
    end else begin
      cf_out = orig;
      jf_out = !orig;
    end
  end
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mem,
  input  logic [2:0]        req_op,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [ADDR_W-1:0] req_ptr,
  input  logic              req_cf,
  input  logic              req_zf,
  // operands presented to the bit datapath
  output logic [DATA_W-1:0] op_data,
  output logic [IDX_W-1:0]  op_idx,
  output logic [2:0]        op_code,
  output logic              op_cf,
  output logic              op_zf,
  // datapath results
  input  logic [DATA_W-1:0] alu_data,
  input  logic              alu_we,
  input  logic              alu_jf,
  input  logic              alu_zf,
  input  logic              alu_cf,
  // results
  output logic              res_valid,
  output logic [DATA_W-1:0] res_byte,
  output logic              res_we,
  output logic              res_jf,
  output logic              res_zf,
  output logic              res_cf,
  // memory side
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_req,
  output logic              mem_rd_latch,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack
);
  bop_state_e        st_q;
  logic              mem_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      mem_q    <= 1'b0;
      ptr_q    <= '0;
      op_data  <= '0;
      op_idx   <= '0;
      op_code  <= '0;
      op_cf    <= 1'b0;
      op_zf    <= 1'b0;
      done_q   <= 1'b0;
      res_byte <= '0;
      res_we   <= 1'b0;
      res_jf   <= 1'b0;
      res_zf   <= 1'b0;
      res_cf   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            mem_q   <= req_mem;
            ptr_q   <= req_ptr;
            op_data <= req_operand;
            op_idx  <= req_idx;
            op_code <= req_op;
            op_cf   <= req_cf;
            op_zf   <= req_zf;
            st_q    <= req_mem ? ST_READ : ST_MODIFY;
          end
        end
        ST_READ: begin
          if (mem_rd_valid) begin
            op_data <= mem_rd_data;
            st_q    <= ST_MODIFY;
          end
        end
        ST_MODIFY: begin
          res_byte <= alu_data;
          res_we   <= alu_we;
          res_jf   <= alu_jf;
          res_zf   <= alu_zf;
          res_cf   <= alu_cf;
          if (mem_q && alu_we) begin
            st_q <= ST_WRITE;
          end else begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: begin
          if (mem_wr_ack) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign req_ready    = (st_q == ST_IDLE);
  assign res_valid    = done_q;
  assign mem_addr     = ptr_q;
  assign mem_rd_req   = (st_q == ST_READ);
  assign mem_rd_latch = (st_q == ST_READ) && op_reads_latch(op_code);
  assign mem_wr_req   = (st_q == ST_WRITE);
  assign mem_wr_data  = res_byte;
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mem,
  input  logic [2:0]        req_op,
  input  logic [SEL_W-1:0]  req_bitsel,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [ADDR_W-1:0] req_ptr,
  input  logic              req_cf,
  input  logic              req_zf,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_byte,
  output logic              res_we,
  output logic              res_jf,
  output logic              res_zf,
  output logic              res_cf,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_req,
  output logic              mem_rd_latch,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack
);
  logic [DATA_W-1:0] op_data, alu_data;
  logic [IDX_W-1:0]  op_idx;
  logic [2:0]        op_code;
  logic              op_cf, op_zf;
  logic              alu_we, alu_jf, alu_zf, alu_cf;
  logic              unused_sel_hi;

  // Only the low index bits of the selector steer the bit position.
  assign unused_sel_hi = ^req_bitsel[SEL_W-1:IDX_W];

  bitop_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_mem(req_mem),
    .req_op(req_op), .req_idx(req_bitsel[IDX_W-1:0]),
    .req_operand(req_operand), .req_ptr(req_ptr),
    .req_cf(req_cf), .req_zf(req_zf),
    .op_data(op_data), .op_idx(op_idx), .op_code(op_code),
    .op_cf(op_cf), .op_zf(op_zf),
    .alu_data(alu_data), .alu_we(alu_we), .alu_jf(alu_jf),
    .alu_zf(alu_zf), .alu_cf(alu_cf),
    .res_valid(res_valid), .res_byte(res_byte), .res_we(res_we),
    .res_jf(res_jf), .res_zf(res_zf), .res_cf(res_cf),
    .mem_addr(mem_addr), .mem_rd_req(mem_rd_req), .mem_rd_latch(mem_rd_latch),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
  );

  bitop_alu #(.DATA_W(DATA_W)) u_alu (
    .data_in(op_data), .idx(op_idx), .op(op_code),
    .cf_in(op_cf), .zf_in(op_zf),
    .data_out(alu_data), .we(alu_we), .jf_out(alu_jf),
    .zf_out(alu_zf), .cf_out(alu_cf)
  );
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic              res_valid,
  input logic              res_we,
  input logic              res_jf,
  input logic              res_zf,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_req,
  input logic              mem_rd_latch,
  input logic              mem_rd_valid,
  input logic              mem_wr_req,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_wr_ack
);
  logic [2:0] op_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_seen <= 3'd0;
    else if (req_valid && req_ready) op_seen <= req_op;
  end

  a_r1_flags_match: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_seen <= 3'd2) |-> (res_jf == res_zf));

  a_r3_store_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_seen == 3'd3) |-> res_jf);

  a_r4_test_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_seen[2]) |-> !res_we);

  a_r7_latch_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_latch |-> mem_rd_req);

  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_req && !mem_wr_req));

  a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_addr)));

  a_r9_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_data)));

  a_r9_no_test_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> !op_seen[2]);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .res_valid(res_valid), .res_we(res_we), .res_jf(res_jf),
  .res_zf(res_zf), .mem_addr(mem_addr), .mem_rd_req(mem_rd_req),
  .mem_rd_latch(mem_rd_latch), .mem_rd_valid(mem_rd_valid),
  .mem_wr_req(mem_wr_req), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
);

// File: tb/bitop_unit_test.sv
module bitop_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_mem = 1'b0, req_cf = 1'b0, req_zf = 1'b0;
  logic [2:0]  req_op = '0;
  logic [7:0]  req_bitsel = '0, req_operand = '0;
  logic [15:0] req_ptr = '0;
  logic        req_ready, res_valid, res_we, res_jf, res_zf, res_cf;
  logic [7:0]  res_byte, mem_rd_data = '0, mem_wr_data;
  logic [15:0] mem_addr;
  logic        mem_rd_req, mem_rd_latch, mem_rd_valid = 1'b0;
  logic        mem_wr_req, mem_wr_ack = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  bitop_unit uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // Behavioural expectation of one operation.
  task automatic model(input int op, input int sel, input int val, input bit cf, input bit zf,
                       output int nbyte, output bit we, output bit jf, output bit nzf, output bit ncf);
    int  pos;
    bit  b;
    pos  = sel % 8;
    b    = ((val >> pos) & 1) != 0;
    nbyte = val; we = 0; jf = 1; nzf = zf; ncf = cf;
    case (op)
      0: begin nbyte = val | (1 << pos);             we = 1; jf = !b; nzf = !b; end
      1: begin nbyte = val & ~(1 << pos) & 255;      we = 1; jf = !b; nzf = !b; end
      2: begin nbyte = b ? val - (1 << pos) : val + (1 << pos); we = 1; jf = !b; nzf = !b; end
      3: begin nbyte = cf ? (val | (1 << pos)) : (val & ~(1 << pos) & 255); we = 1; jf = 1; end
      4, 6: begin ncf = b; jf = !b; end
      default: begin ncf = cf ^ b; jf = cf ^ b; end
    endcase
  endtask

  task automatic run_op(input bit mem, input int op, input int sel, input int val,
                        input bit cf, input bit zf, input int rlat, input int wlat,
                        input int ptr, input string tag);
    int eb; bit ewe, ejf, ezf, ecf;
    model(op, sel, val, cf, zf, eb, ewe, ejf, ezf, ecf);
    @(negedge clk);
    chk(req_ready === 1'b1, {tag, " R8 ready before request"}, req_ready, 1);
    req_valid = 1; req_mem = mem; req_op = 3'(op); req_bitsel = 8'(sel);
    req_operand = mem ? 8'h5A : 8'(val); req_ptr = 16'(ptr); req_cf = cf; req_zf = zf;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready === 1'b0, {tag, " R8 busy after accept"}, req_ready, 0);
    if (mem) begin
      for (int k = 0; k < rlat; k++) begin
        chk(mem_rd_req === 1'b1, {tag, " R8 read held"}, mem_rd_req, 1);
        chk(mem_addr === 16'(ptr), {tag, " R8 read address"}, mem_addr, ptr);
        chk(mem_rd_latch === (op == 1 || op == 2), {tag, " R7 latch qualifier"},
            mem_rd_latch, (op == 1 || op == 2));
        if (k == rlat - 1) begin mem_rd_valid = 1; mem_rd_data = 8'(val); end
        @(negedge clk);
        mem_rd_valid = 0;
      end
      chk(mem_rd_req === 1'b0 && res_valid === 1'b0, {tag, " R10 no early done"}, res_valid, 0);
      @(negedge clk);
      if (ewe) begin
        for (int k = 0; k < wlat; k++) begin
          chk(mem_wr_req === 1'b1, {tag, " R9 write held"}, mem_wr_req, 1);
          chk(mem_wr_data === 8'(eb), {tag, " R9 write data"}, mem_wr_data, eb);
          chk(mem_addr === 16'(ptr), {tag, " R9 write address"}, mem_addr, ptr);
          chk(res_valid === 1'b0, {tag, " R10 done waits for ack"}, res_valid, 0);
          if (k == wlat - 1) mem_wr_ack = 1;
          @(negedge clk);
          mem_wr_ack = 0;
        end
      end else begin
        chk(mem_wr_req === 1'b0, {tag, " R9 write skipped"}, mem_wr_req, 0);
      end
    end else begin
      chk(res_valid === 1'b0, {tag, " R10 not yet done"}, res_valid, 0);
      @(negedge clk);
    end
    chk(res_valid === 1'b1, {tag, " R10 done pulse"}, res_valid, 1);
    chk(res_byte === 8'(eb), {tag, " R2 R3 byte"}, res_byte, eb);
    chk(res_we === ewe, {tag, " R4 R5 write enable"}, res_we, ewe);
    chk(res_jf === ejf, {tag, " R1 R3 R4 R5 jump flag"}, res_jf, ejf);
    chk(res_zf === ezf, {tag, " R1 zero flag"}, res_zf, ezf);
    chk(res_cf === ecf, {tag, " R4 R5 carry flag"}, res_cf, ecf);
    chk(mem_wr_req === 1'b0, {tag, " R9 write released"}, mem_wr_req, 0);
    @(negedge clk);
    chk(res_valid === 1'b0, {tag, " R10 pulse one cycle"}, res_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R11 ready in reset", req_ready, 1);
    chk(res_valid === 1'b0, "R11 done low in reset", res_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_rd_req === 1'b0 && mem_wr_req === 1'b0,
        "R11 idle after reset", {req_ready, mem_rd_req, mem_wr_req}, 3'b100);
    // register form
    run_op(0, 0, 0, 8'h00, 0, 0, 0, 0, 0, "R1 set on clear bit");
    run_op(0, 0, 7, 8'h80, 1, 0, 0, 0, 0, "R1 set on set bit");
    run_op(0, 1, 3, 8'hFF, 0, 0, 0, 0, 0, "R2 clear among ones");
    run_op(0, 1, 4, 8'h00, 1, 1, 0, 0, 0, "R2 clear on zero");
    run_op(0, 2, 5, 8'hDF, 0, 0, 0, 0, 0, "R2 invert zero bit");
    run_op(0, 2, 6, 8'h41, 1, 1, 0, 0, 0, "R2 invert one bit");
    run_op(0, 3, 2, 8'h00, 1, 0, 0, 0, 0, "R3 store carry one");
    run_op(0, 3, 1, 8'hFF, 0, 1, 0, 0, 0, "R3 store carry zero");
    run_op(0, 4, 1, 8'h02, 0, 1, 0, 0, 0, "R4 test one");
    run_op(0, 6, 0, 8'hFE, 1, 0, 0, 0, 0, "R4 test zero alt code");
    run_op(0, 5, 3, 8'h08, 1, 0, 0, 0, 0, "R5 xor one one");
    run_op(0, 5, 3, 8'h00, 1, 1, 0, 0, 0, "R5 xor one zero");
    run_op(0, 7, 7, 8'h80, 0, 0, 0, 0, 0, "R5 xor zero one alt code");
    run_op(0, 0, 8'hFA, 8'h00, 0, 0, 0, 0, 0, "R6 upper selector bits");
    run_op(0, 1, 8'h0D, 8'hFF, 0, 0, 0, 0, 0, "R6 upper selector bit 3");
    // memory form
    run_op(1, 1, 3, 8'hA8, 0, 0, 3, 2, 16'h1234, "R7 memory clear");
    run_op(1, 0, 0, 8'h10, 1, 1, 1, 1, 16'hBEEF, "R9 memory set");
    run_op(1, 2, 7, 8'h7F, 0, 0, 2, 4, 16'h0042, "R7 memory invert");
    run_op(1, 3, 5, 8'h00, 1, 0, 1, 3, 16'hFFFF, "R3 memory store");
    run_op(1, 4, 2, 8'h04, 0, 1, 4, 1, 16'h8001, "R9 memory test no write");
    run_op(1, 5, 6, 8'h40, 1, 0, 2, 1, 16'h0100, "R9 memory xor no write");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule